// File: doc/BRIEF.md
# Auto-Incrementing Glyph ROM Sequencer

This block forms the address and the active-low chip enable for an external 256 KB character-graphics ROM that the CPU sees through a 4 KB window at $5000–$5FFF. Each glyph is 32 bytes: a 16x16 picture at one bit per pixel. The low twelve CPU address bits choose the glyph. The byte inside the glyph does not come from the CPU address. It comes from a hidden 5-bit counter that steps once per bus access to the window. Software can therefore stream a whole glyph by reading the same location 32 times.

A control register sits at $40B0 and is mirrored at $41B0. Bit 0 of a write to it picks which 128 KB half of the ROM the window shows, and it drives ROM address bit 17. Any read of the register rewinds the byte counter to 0. The block updates its state on the falling edge of M2, which is the end of each CPU bus cycle. The ROM data path is outside this block.

Top module: `glyph_rom_seq`

## Requirements
- R1: `rom_ce_n` is 0 exactly when `romsel_n` is 1 and `cpu_addr[15:12]` equals 4'h5. Otherwise it is 1. This output is combinational.
- R2: `rom_addr[16:5]` equals `cpu_addr[11:0]` and `rom_addr[4:0]` equals the byte counter.
- R3: At each falling edge of M2 on which R1 enables the ROM, the byte counter increments by one. This holds for reads (`cpu_rw`=1) and for writes (`cpu_rw`=0).
- R4: At a falling edge of M2 with no window access and no control-register read, the byte counter keeps its value.
- R5: A read (`cpu_rw`=1) of the control register at $40B0 or at $41B0 sets the byte counter to 0 at that falling edge of M2.
- R6: A write (`cpu_rw`=0) to the control register loads `cpu_wdata[0]` into the bank bit, which appears on `rom_addr[17]`. Bits 7..1 of the write data are ignored.
- R7: While `rst_n` is 0, the byte counter and the bank bit are 0. The reset is asynchronous.
- R8: The counter wraps from 31 to 0, so the 33rd consecutive window access after a rewind addresses byte 0 of the glyph again.
- R9: The control register decodes only when `romsel_n` is 1, `cpu_addr[15:12]`=4'h4, `cpu_addr[11:9]`=0 and `cpu_addr[7:0]`=8'hB0, with bit 8 ignored. A write to it leaves the counter unchanged. Addresses such as $42B0 or $40B1 neither rewind the counter nor load the bank bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m2 | input | 1 | CPU bus phase clock; state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| romsel_n | input | 1 | Active-low cartridge ROM select from the CPU side |
| cpu_wdata | input | 8 | CPU write data |
| rom_addr | output | 18 | ROM address: bank bit, glyph index, byte counter |
| rom_ce_n | output | 1 | Active-low ROM chip enable |

## Verification
The window is driven with runs of reads, runs of writes and bus cycles outside it. This separates counting on every window access from counting only on reads, and from counting on any cycle at all. A rewind is followed by 33 straight reads, so an off-by-one wrap or a counter that saturates shows up on the last read. The control register is hit at its base address and at its mirror, and also at near-miss addresses ($42B0, $40B1, $40A0). Writes are made with bit 0 set and cleared and with the other bits toggled. These cases tell a loose or over-strict address decode apart from the correct one. They also show that a write never rewinds the counter and that a read never changes the bank bit.

// File: rtl/glyph_seq_pkg.sv
package glyph_seq_pkg;
   localparam int ADDR_W   = 16;
   localparam int DATA_W   = 8;
   localparam int WIN_W    = 12;
   localparam int CNT_W    = 5;
   localparam int TAG_W    = ADDR_W - WIN_W;
   localparam int ROM_AW   = CNT_W + WIN_W + 1;

   typedef enum logic [1:0] {
      OP_IDLE    = 2'd0,
      OP_WINDOW  = 2'd1,
      OP_CTRL_RD = 2'd2,
      OP_CTRL_WR = 2'd3
   } glyph_op_e;
endpackage

// File: rtl/glyph_bus_decode.sv
module glyph_bus_decode
   import glyph_seq_pkg::*;
#(
   parameter int              P_ADDR_W    = ADDR_W,
   parameter int              P_WIN_W     = WIN_W,
   parameter logic [3:0]      P_WIN_TAG   = 4'h5,
   parameter logic [15:0]     P_CTRL_ADDR = 16'h40B0,
   parameter bit              P_MIRROR_EN = 1'b1,
   parameter int              P_MIRROR_BIT = 8
) (
   input  logic [P_ADDR_W-1:0] cpu_addr,
   input  logic                cpu_rw,
   input  logic                romsel_n,
   output glyph_op_e           op
);
   localparam int L_TAG_W = P_ADDR_W - P_WIN_W;

   logic [P_ADDR_W-1:0] ctrl_mask;
   logic                win_hit;
   logic                ctrl_hit;

   generate
      if (P_MIRROR_EN) begin : g_mirror
         always_comb begin
            ctrl_mask = '1;
            ctrl_mask[P_MIRROR_BIT] = 1'b0;
         end
      end else begin : g_exact
         assign ctrl_mask = '1;
      end
   endgenerate

   assign win_hit  = romsel_n &&
                     (cpu_addr[P_ADDR_W-1 -: L_TAG_W] == L_TAG_W'(P_WIN_TAG));
   assign ctrl_hit = romsel_n &&
                     ((cpu_addr & ctrl_mask) == (P_ADDR_W'(P_CTRL_ADDR) & ctrl_mask));

   always_comb begin
      op = OP_IDLE;
      if (win_hit)
         op = OP_WINDOW;
      else if (ctrl_hit)
         op = cpu_rw ? OP_CTRL_RD : OP_CTRL_WR;
   end
endmodule

// File: rtl/glyph_byte_counter.sv
module glyph_byte_counter #(
   parameter int P_CNT_W = 5
) (
   input  logic               m2,
   input  logic               rst_n,
   input  logic               step,
   input  logic               clear,
   output logic [P_CNT_W-1:0] cnt
);
   always_ff @(negedge m2 or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
   end

   // R3: one step per window access
   p_step_r3: assert property (@(negedge m2) disable iff (!rst_n)
      (step && !clear) |=> cnt == P_CNT_W'($past(cnt) + 1'b1));
   // R4: no access, no movement
   p_hold_r4: assert property (@(negedge m2) disable iff (!rst_n)
      (!step && !clear) |=> $stable(cnt));
   // R5: register read rewinds
   p_clear_r5: assert property (@(negedge m2) disable iff (!rst_n)
      clear |=> cnt == '0);
   // R8: top value rolls to zero
   p_wrap_r8: assert property (@(negedge m2) disable iff (!rst_n)
      (step && !clear && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/glyph_bank_reg.sv
module glyph_bank_reg #(
   parameter int P_DATA_W   = 8,
   parameter int P_BANK_BIT = 0
) (
   input  logic                m2,
   input  logic                rst_n,
   input  logic                load,
   input  logic [P_DATA_W-1:0] wdata,
   output logic                bank
);
   always_ff @(negedge m2 or negedge rst_n) begin
      if (!rst_n)
         bank <= 1'b0;
      else if (load)
         bank <= wdata[P_BANK_BIT];
   end

   // R6: write loads the selected data bit
   p_load_r6: assert property (@(negedge m2) disable iff (!rst_n)
      load |=> bank == $past(wdata[P_BANK_BIT]));
   // R9: anything but a register write leaves the bank alone
   p_keep_r9: assert property (@(negedge m2) disable iff (!rst_n)
      !load |=> $stable(bank));
endmodule

// File: rtl/glyph_rom_seq.sv
module glyph_rom_seq
   import glyph_seq_pkg::*;
#(
   parameter int          P_ADDR_W     = ADDR_W,
   parameter int          P_DATA_W     = DATA_W,
   parameter int          P_WIN_W      = WIN_W,
   parameter int          P_CNT_W      = CNT_W,
   parameter logic [3:0]  P_WIN_TAG    = 4'h5,
   parameter logic [15:0] P_CTRL_ADDR  = 16'h40B0,
   parameter bit          P_MIRROR_EN  = 1'b1,
   parameter int          P_MIRROR_BIT = 8,
   parameter int          P_BANK_BIT   = 0
) (
   input  logic                                m2,
   input  logic                                rst_n,
   input  logic [P_ADDR_W-1:0]                 cpu_addr,
   input  logic                                cpu_rw,
   input  logic                                romsel_n,
   input  logic [P_DATA_W-1:0]                 cpu_wdata,
   output logic [P_CNT_W+P_WIN_W:0]            rom_addr,
   output logic                                rom_ce_n
);
   localparam int L_TAG_W = P_ADDR_W - P_WIN_W;

   generate
      if (P_WIN_W >= P_ADDR_W) begin : g_bad_win
         $error("window width must be below the address width");
      end
      if (L_TAG_W > 4) begin : g_bad_tag
         $error("window tag wider than its parameter");
      end
      if (P_BANK_BIT >= P_DATA_W) begin : g_bad_bank
         $error("bank bit outside the data bus");
      end
      if (P_MIRROR_EN && (P_MIRROR_BIT >= P_ADDR_W)) begin : g_bad_mirror
         $error("mirror bit outside the address bus");
      end
      if (P_CNT_W < 1) begin : g_bad_cnt
         $error("byte counter needs at least one bit");
      end
   endgenerate

   glyph_op_e            op;
   logic [P_CNT_W-1:0]   byte_cnt;
   logic                 bank;

   glyph_bus_decode #(
      .P_ADDR_W     (P_ADDR_W),
      .P_WIN_W      (P_WIN_W),
      .P_WIN_TAG    (P_WIN_TAG),
      .P_CTRL_ADDR  (P_CTRL_ADDR),
      .P_MIRROR_EN  (P_MIRROR_EN),
      .P_MIRROR_BIT (P_MIRROR_BIT)
   ) u_decode (
      .cpu_addr (cpu_addr),
      .cpu_rw   (cpu_rw),
      .romsel_n (romsel_n),
      .op       (op)
   );

   glyph_byte_counter #(
      .P_CNT_W (P_CNT_W)
   ) u_counter (
      .m2    (m2),
      .rst_n (rst_n),
      .step  (op == OP_WINDOW),
      .clear (op == OP_CTRL_RD),
      .cnt   (byte_cnt)
   );

   glyph_bank_reg #(
      .P_DATA_W   (P_DATA_W),
      .P_BANK_BIT (P_BANK_BIT)
   ) u_bank (
      .m2    (m2),
      .rst_n (rst_n),
      .load  (op == OP_CTRL_WR),
      .wdata (cpu_wdata),
      .bank  (bank)
   );

   assign rom_ce_n = (op != OP_WINDOW);
   assign rom_addr = {bank, cpu_addr[P_WIN_W-1:0], byte_cnt};

   // R1: enable only inside the window and only with the cartridge select idle
   p_ce_window_r1: assert property (@(negedge m2) disable iff (!rst_n)
      !rom_ce_n |-> (romsel_n && cpu_addr[P_ADDR_W-1 -: L_TAG_W] == L_TAG_W'(P_WIN_TAG)));
   // R9: register traffic never enables the ROM
   p_ctrl_no_ce_r9: assert property (@(negedge m2) disable iff (!rst_n)
      (op == OP_CTRL_RD || op == OP_CTRL_WR) |-> rom_ce_n);
endmodule

// File: tb/tb_glyph_rom_seq.sv
module tb_glyph_rom_seq;
   localparam int T_M2 = 20;
   localparam int WDOG_CYCLES = 5000;

   logic        m2 = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_rw = 1'b1;
   logic        romsel_n = 1'b1;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [17:0] rom_addr;
   logic        rom_ce_n;

   int n_chk = 0;
   int n_bad = 0;
   int mcnt  = 0;
   int mbank = 0;
   int cycles = 0;
   bit done = 1'b0;

   glyph_rom_seq dut (
      .m2        (m2),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_rw    (cpu_rw),
      .romsel_n  (romsel_n),
      .cpu_wdata (cpu_wdata),
      .rom_addr  (rom_addr),
      .rom_ce_n  (rom_ce_n)
   );

   always #(T_M2/2) m2 = ~m2;

   function automatic bit in_win(input logic [15:0] a, input logic rs);
      return rs && (a >= 16'h5000) && (a <= 16'h5FFF);
   endfunction

   function automatic bit is_ctrl(input logic [15:0] a, input logic rs);
      return rs && (a == 16'h40B0 || a == 16'h41B0);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   // one bus cycle: present inputs, compare at M2 high, update model after M2 falls
   task automatic cyc(input logic [15:0] a, input logic rw, input logic [7:0] d,
                      input logic rs, input string tag);
      cpu_addr = a; cpu_rw = rw; cpu_wdata = d; romsel_n = rs;
      @(posedge m2); #1;
      chk("R1 ce", int'(rom_ce_n), in_win(a, rs) ? 0 : 1);
      chk({tag, " byte"}, int'(rom_addr[4:0]), mcnt);
      chk("R2 glyph", int'(rom_addr[16:5]), int'(a[11:0]));
      chk("R6 bank", int'(rom_addr[17]), mbank);
      @(negedge m2); #1;
      if (rst_n) begin
         if (is_ctrl(a, rs) && rw)  mcnt = 0;
         if (is_ctrl(a, rs) && !rw) mbank = int'(d[0]);
         if (in_win(a, rs))         mcnt = (mcnt + 1) % 32;
      end
   endtask

   initial begin : watchdog
      while (cycles < WDOG_CYCLES) begin
         @(posedge m2);
         cycles++;
      end
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG_CYCLES);
      finish_run();
   end

   initial begin : stim
      // R7: window accesses under reset do not move anything
      for (int i = 0; i < 3; i++) cyc(16'h5000, 1'b1, 8'h00, 1'b1, "R7");
      rst_n = 1'b1;
      // R3: reads step the counter
      for (int i = 0; i < 5; i++) cyc(16'h5000, 1'b1, 8'h00, 1'b1, "R3");
      // R4: outside the window the counter holds
      for (int i = 0; i < 3; i++) cyc(16'h0300, 1'b1, 8'h00, 1'b1, "R4");
      cyc(16'hC000, 1'b1, 8'h00, 1'b0, "R4");
      cyc(16'h5000, 1'b1, 8'h00, 1'b0, "R1");
      cyc(16'h4FFF, 1'b1, 8'h00, 1'b1, "R4");
      // R3: writes into the window also step
      for (int i = 0; i < 2; i++) cyc(16'h5123, 1'b0, 8'hA5, 1'b1, "R3");
      // R5: read of the register rewinds
      cyc(16'h40B0, 1'b1, 8'h00, 1'b1, "R5");
      // R8: 33 reads, the last one back at byte 0
      for (int i = 0; i < 33; i++) cyc(16'h5ABC, 1'b1, 8'h00, 1'b1, "R8");
      for (int i = 0; i < 2; i++) cyc(16'h5FFF, 1'b1, 8'h00, 1'b1, "R3");
      // R9: near-miss addresses do not rewind
      cyc(16'h42B0, 1'b1, 8'h00, 1'b1, "R9");
      cyc(16'h40B1, 1'b1, 8'h00, 1'b1, "R9");
      cyc(16'h40A0, 1'b1, 8'h00, 1'b1, "R9");
      cyc(16'h40B0, 1'b1, 8'h00, 1'b0, "R9");
      cyc(16'h5001, 1'b1, 8'h00, 1'b1, "R9");
      // R5: mirror read rewinds too
      cyc(16'h41B0, 1'b1, 8'h00, 1'b1, "R5");
      for (int i = 0; i < 4; i++) cyc(16'h5010, 1'b1, 8'h00, 1'b1, "R5");
      // R9/R6: register write sets bank, counter untouched
      cyc(16'h40B0, 1'b0, 8'h01, 1'b1, "R9");
      cyc(16'h5FFF, 1'b1, 8'h00, 1'b1, "R6");
      cyc(16'h40B0, 1'b0, 8'hFE, 1'b1, "R6");
      cyc(16'h5FFF, 1'b1, 8'h00, 1'b1, "R6");
      cyc(16'h42B0, 1'b0, 8'h01, 1'b1, "R9");
      cyc(16'h40B8, 1'b0, 8'h01, 1'b1, "R9");
      cyc(16'h5002, 1'b1, 8'h00, 1'b1, "R9");
      cyc(16'h41B0, 1'b0, 8'h03, 1'b1, "R6");
      cyc(16'h5003, 1'b1, 8'h00, 1'b1, "R6");
      // R7: asynchronous reset clears counter and bank
      rst_n = 1'b0;
      #(T_M2/4);
      chk("R7 byte", int'(rom_addr[4:0]), 0);
      chk("R7 bank", int'(rom_addr[17]), 0);
      mcnt = 0;
      mbank = 0;
      @(negedge m2); #1;
      rst_n = 1'b1;
      cyc(16'h5004, 1'b1, 8'h00, 1'b1, "R7");
      cyc(16'h5004, 1'b1, 8'h00, 1'b1, "R3");
      finish_run();
   end
endmodule